// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a set of level-sensitive interrupt request lines onto the single interrupt input of a processor. Line 0 is a non-maskable request; the remaining lines are ordinary sources. Every request is caught in a pending register. A per-source mask, a global enable and a priority threshold decide which pending requests may reach the processor. Among the requests that may, the one with the lowest line index wins. Its line index is the vector number that the processor's handler uses to index its table of handler addresses.

Nested service is tracked in a small in-service stack. The processor takes a request by pulsing an acknowledge input. In that cycle the winning source moves from pending to in-service, and the vector register latches its number. A new request only interrupts the handler in service if it is strictly more urgent. The handler signals completion by writing the end-of-interrupt register. This pops the innermost service and drops that source's pending bit, so deferred requests of equal or lower urgency are then delivered. Mask, threshold, enable, end-of-interrupt, service depth and pending state are reached through a four-word register port with combinational reads.

Top module: `pvic_top`

## Requirements
- R1: After reset: `irq_o` is low, `vec_o` is 0, and the in-service depth and all pending bits are 0. The mask register (address 0, bit i masks line i) reads all ones except bit 0, which always reads 0. The control register (address 1: threshold in bits [VW-1:0], global enable in bit DW-1) reads threshold NSRC-1 with enable 0.
- R2: A high level on a request line sets its pending bit at the next clock edge. The bit stays set after the line drops, and can be read at address 3 (bit i = line i).
- R3: A pending request from a masked line is held. It is delivered once its mask bit is cleared.
- R4: A maskable line whose index is greater than the threshold is held off. It is delivered once the threshold is raised to at least its index.
- R5: With the global enable at 0, no maskable line can raise `irq_o`.
- R6: Lower line index means higher priority. When `int_ack_i` is high while `irq_o` is high, `vec_o` takes the index of the winning line one cycle later and keeps it until the next such acknowledge.
- R7: Line 0 is delivered with vector 0 regardless of mask, threshold and global enable.
- R8: An accepted acknowledge pushes the winner onto the in-service stack; the depth read at address 2 grows by one. The winner's pending bit is cleared unless its line is still high in that cycle. An acknowledge while `irq_o` is low has no effect.
- R9: While a service is active, `irq_o` rises only for an eligible line with an index strictly lower than the innermost in-service line.
- R10: A write to address 2 with a non-empty stack pops the innermost service and clears that line's pending bit, unless its line is high. Held requests of equal or lower priority are then delivered.
- R11: When an accepted acknowledge and an end-of-interrupt fall in the same cycle, the new winner replaces the innermost entry. The depth is unchanged, and the pending bits of both lines are cleared.
- R12: An end-of-interrupt write with an empty stack changes neither the depth nor the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | NSRC | Level request lines; line 0 is non-maskable |
| int_ack_i | input | 1 | Processor takes the current request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 control, 2 service, 3 pending |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational on address |
| irq_o | output | 1 | Merged interrupt request to the processor |
| vec_o | output | VW | Vector of the last accepted request |

## Verification
The acknowledge of a newly preempting request and the end-of-interrupt of the innermost service can land in the same cycle. The directed sequence forces this: it raises a more urgent line while one service is active, then pulses the acknowledge and writes the service register together. The result is judged by reading the service depth, which must be unchanged, and the pending word, which must have lost both bits, and by checking that the vector now names the preempting line. The random phase issues acknowledges and end-of-interrupt writes independently, so the coincidence recurs many times and is compared every cycle against the bench model.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    // Register select decoded from the two-bit address.
    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_CTRL = 2'd1,
        REG_SVC  = 2'd2,
        REG_PEND = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pvic_pending.sv
// Pending latch: level lines set bits, clear requests drop them, set wins.
module pvic_pending #(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/pvic_select.sv
// Eligibility filter and fixed-priority pick (lowest index wins),
// followed by the preemption test against the innermost service.
module pvic_select #(
    parameter int N  = 8,
    parameter int VW = 3
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  mask_i,
    input  logic          en_i,
    input  logic [VW-1:0] thr_i,
    input  logic          empty_i,
    input  logic [VW-1:0] top_i,
    output logic [VW-1:0] cand_o,
    output logic          fire_o
);

    logic [N-1:0] elig;
    logic         any_elig;
    logic         unused_mask;

    assign unused_mask = mask_i[0];

    for (genvar i = 0; i < N; i++) begin : g_elig
        if (i == 0) begin : g_nmi
            assign elig[i] = pend_i[i];
        end else begin : g_std
            assign elig[i] = pend_i[i] & ~mask_i[i] & en_i & (VW'(i) <= thr_i);
        end
    end

    always_comb begin
        cand_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                cand_o = VW'(i);
            end
        end
    end

    assign any_elig = |elig;
    assign fire_o   = any_elig & (empty_i | (cand_o < top_i));

endmodule

// File: rtl/pvic_stack.sv
// In-service stack. Push and pop together replace the top entry.
module pvic_stack #(
    parameter int N   = 8,
    parameter int VW  = 3,
    parameter int SPW = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           push_i,
    input  logic           pop_i,
    input  logic [VW-1:0]  vec_i,
    output logic [VW-1:0]  top_o,
    output logic [SPW-1:0] depth_o,
    output logic           empty_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0][VW-1:0] stk;
        logic [SPW-1:0]       sp;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i && pop_i && (st_q.sp != '0)) begin
            st_d.stk[IW'(st_q.sp - 1'b1)] = vec_i;
        end else if (push_i && (st_q.sp < SPW'(N))) begin
            st_d.stk[IW'(st_q.sp)] = vec_i;
            st_d.sp                = st_q.sp + 1'b1;
        end else if (pop_i && (st_q.sp != '0)) begin
            st_d.sp = st_q.sp - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_o = (st_q.sp == '0);
    assign depth_o = st_q.sp;
    assign top_o   = empty_o ? '0 : st_q.stk[IW'(st_q.sp - 1'b1)];

endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
    parameter int NSRC = 8,
    parameter int DW   = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NSRC-1:0]           irq_lines_i,
    input  logic                      int_ack_i,
    input  logic                      reg_we_i,
    input  logic [1:0]                reg_addr_i,
    input  logic [DW-1:0]             reg_wdata_i,
    output logic [DW-1:0]             reg_rdata_o,
    output logic                      irq_o,
    output logic [$clog2(NSRC)-1:0]   vec_o
);

    import pvic_pkg::*;

    localparam int VW  = $clog2(NSRC);
    localparam int SPW = $clog2(NSRC + 1);

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [VW-1:0]   thr;
        logic            en;
        logic [VW-1:0]   vec;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    reg_sel_e        sel_w;
    logic [NSRC-1:0] pend_w;
    logic [NSRC-1:0] clr_w;
    logic [VW-1:0]   cand_w;
    logic            fire_w;
    logic [VW-1:0]   top_w;
    logic [SPW-1:0]  depth_w;
    logic            empty_w;
    logic            take_w;
    logic            eoi_w;
    logic            gie_w;
    logic            unused_wdata;

    assign sel_w        = reg_sel_e'(reg_addr_i);
    assign unused_wdata = ^reg_wdata_i;
    assign gie_w        = cfg_q.en;

    assign take_w = int_ack_i & fire_w;
    assign eoi_w  = reg_we_i & (sel_w == REG_SVC) & ~empty_w;
    assign clr_w  = (take_w ? (NSRC'(1) << cand_w) : '0)
                  | (eoi_w  ? (NSRC'(1) << top_w)  : '0);

    pvic_pending #(.N(NSRC)) u_pend (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (irq_lines_i),
        .clr_i  (clr_w),
        .pend_o (pend_w)
    );

    pvic_select #(.N(NSRC), .VW(VW)) u_sel (
        .pend_i  (pend_w),
        .mask_i  (cfg_q.mask),
        .en_i    (cfg_q.en),
        .thr_i   (cfg_q.thr),
        .empty_i (empty_w),
        .top_i   (top_w),
        .cand_o  (cand_w),
        .fire_o  (fire_w)
    );

    pvic_stack #(.N(NSRC), .VW(VW), .SPW(SPW)) u_stk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (take_w),
        .pop_i   (eoi_w),
        .vec_i   (cand_w),
        .top_o   (top_w),
        .depth_o (depth_w),
        .empty_o (empty_w)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (take_w) begin
            cfg_d.vec = cand_w;
        end
        if (reg_we_i) begin
            case (sel_w)
                REG_MASK: cfg_d.mask = reg_wdata_i[NSRC-1:0] & ~NSRC'(1);
                REG_CTRL: begin
                    cfg_d.thr = reg_wdata_i[VW-1:0];
                    cfg_d.en  = reg_wdata_i[DW-1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q      <= '0;
            cfg_q.mask <= ~NSRC'(1);
            cfg_q.thr  <= VW'(NSRC - 1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (sel_w)
            REG_MASK: reg_rdata_o[NSRC-1:0] = cfg_q.mask;
            REG_CTRL: begin
                reg_rdata_o[VW-1:0] = cfg_q.thr;
                reg_rdata_o[DW-1]   = cfg_q.en;
            end
            REG_SVC:  reg_rdata_o[SPW-1:0]  = depth_w;
            REG_PEND: reg_rdata_o[NSRC-1:0] = pend_w;
            default: ;
        endcase
    end

    assign irq_o = fire_w;
    assign vec_o = cfg_q.vec;

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
    parameter int NSRC = 8,
    parameter int VW   = 3,
    parameter int SPW  = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            irq_o,
    input logic            take_w,
    input logic            eoi_w,
    input logic [SPW-1:0]  depth_w,
    input logic [VW-1:0]   vec_o,
    input logic [VW-1:0]   cand_w,
    input logic [NSRC-1:0] pend_w,
    input logic            gie_w
);

    p_vec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_w |=> vec_o == $past(cand_w));

    p_push_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_w && !eoi_w) |=> depth_w == SPW'($past(depth_w) + 1'b1));

    p_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_w && !take_w) |=> depth_w == SPW'($past(depth_w) - 1'b1));

    p_swap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_w && take_w) |=> $stable(depth_w));

    p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (depth_w == '0 && !take_w) |=> depth_w == '0);

    p_nmi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_w[0] && depth_w == '0) |-> irq_o);

    p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gie_w && !pend_w[0]) |-> !irq_o);

    p_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        depth_w <= SPW'(NSRC));

endmodule

bind pvic_top pvic_checker #(.NSRC(NSRC), .VW(VW), .SPW(SPW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_o   (irq_o),
    .take_w  (take_w),
    .eoi_w   (eoi_w),
    .depth_w (depth_w),
    .vec_o   (vec_o),
    .cand_w  (cand_w),
    .pend_w  (pend_w),
    .gie_w   (gie_w)
);

// File: tb/pvic_top_tb.sv
module pvic_top_tb;

    localparam int N     = 8;
    localparam int DW    = 16;
    localparam int VW    = 3;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  lines = '0;
    logic          ack_i = 1'b0;
    logic          we_i = 1'b0;
    logic [1:0]    addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          irq_o;
    logic [VW-1:0] vec_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [DW-1:0] last_rd;

    // Reference model state
    logic [N-1:0] m_pend;
    logic [N-1:0] m_mask;
    int           m_thr;
    logic         m_en;
    int           m_stk [N];
    int           m_sp;
    int           m_vec;

    always #(CLK_P / 2) clk = ~clk;

    pvic_top #(.NSRC(N), .DW(DW)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_lines_i (lines),
        .int_ack_i   (ack_i),
        .reg_we_i    (we_i),
        .reg_addr_i  (addr_i),
        .reg_wdata_i (wdata_i),
        .reg_rdata_o (rdata_o),
        .irq_o       (irq_o),
        .vec_o       (vec_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic m_eval(output int c, output logic f);
        c = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_pend[i] && (i == 0 || (!m_mask[i] && m_en && i <= m_thr)))
                c = i;
        end
        f = (c >= 0) && (m_sp == 0 || c < m_stk[m_sp - 1]);
    endtask

    function automatic logic [DW-1:0] m_read(input logic [1:0] a);
        logic [DW-1:0] r = '0;
        case (a)
            2'd0: r[N-1:0] = m_mask;
            2'd1: begin r[VW-1:0] = VW'(m_thr); r[DW-1] = m_en; end
            2'd2: r = DW'(m_sp);
            default: r[N-1:0] = m_pend;
        endcase
        return r;
    endfunction

    task automatic m_reset();
        m_pend = '0; m_mask = ~N'(1); m_thr = N - 1; m_en = 0;
        m_sp = 0; m_vec = 0;
        for (int i = 0; i < N; i++) m_stk[i] = 0;
    endtask

    task automatic step(input logic [N-1:0] ln, input logic ack, input logic we,
                        input logic [1:0] a, input logic [DW-1:0] wd, input string tag);
        int c; logic f; logic take; logic eoi; logic [N-1:0] clr;
        @(negedge clk);
        lines = ln; ack_i = ack; we_i = we; addr_i = a; wdata_i = wd;
        #1;
        m_eval(c, f);
        last_rd = rdata_o;
        chk(tag, irq_o, f);
        chk(tag, vec_o, m_vec);
        if (!we) chk(tag, rdata_o, m_read(a));
        take = ack && f;
        eoi  = we && a == 2'd2 && m_sp != 0;
        clr  = '0;
        if (take) clr[c] = 1'b1;
        if (eoi)  clr[m_stk[m_sp - 1]] = 1'b1;
        m_pend = (m_pend & ~clr) | ln;
        if (take && eoi) m_stk[m_sp - 1] = c;
        else if (take) begin m_stk[m_sp] = c; m_sp++; end
        else if (eoi) m_sp--;
        if (take) m_vec = c;
        if (we && a == 2'd0) m_mask = wd[N-1:0] & ~N'(1);
        if (we && a == 2'd1) begin m_thr = int'(wd[VW-1:0]); m_en = wd[DW-1]; end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic [1:0] a, input string tag);
        step('0, 1'b0, 1'b0, a, '0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, input string tag);
        step('0, 1'b0, 1'b1, a, d, tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] held;
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        idle(2'd0, "R1"); chk("R1 mask", last_rd, 16'h00FE);
        idle(2'd1, "R1"); chk("R1 ctrl", last_rd, 16'h0007);
        idle(2'd2, "R1"); chk("R1 depth", last_rd, 0);
        idle(2'd3, "R1"); chk("R1 pend", last_rd, 0);
        chk("R1 irq", irq_o, 0);

        // R7: line 0 passes masks, threshold and disabled enable
        step(8'h01, 0, 0, 2'd3, 0, "R7");
        chk("R7 irq", irq_o, 1);
        step('0, 1, 0, 2'd3, 0, "R7");
        chk("R7 vec", vec_o, 0);
        idle(2'd2, "R8"); chk("R8 depth", last_rd, 1);
        wr(2'd2, 0, "R10");
        chk("R10 irq", irq_o, 0);

        // R5, R3, R2: held masked request
        step(8'h20, 0, 0, 2'd3, 0, "R5");
        chk("R5 irq", irq_o, 0);
        wr(2'd1, 16'h8007, "R3");
        chk("R3 still masked", irq_o, 0);
        wr(2'd0, 16'h0000, "R3");
        chk("R3 irq", irq_o, 1);
        idle(2'd3, "R2"); chk("R2 pend", last_rd, 16'h0020);

        // R6, R9: priority and nesting
        step(8'h48, 0, 0, 2'd3, 0, "R6");
        step('0, 1, 0, 2'd3, 0, "R6");
        chk("R6 vec", vec_o, 3);
        chk("R9 lower held", irq_o, 0);
        step(8'h04, 0, 0, 2'd3, 0, "R9");
        chk("R9 higher", irq_o, 1);
        step('0, 1, 0, 2'd3, 0, "R6");
        chk("R6 vec2", vec_o, 2);
        step(8'h04, 0, 0, 2'd3, 0, "R9");
        chk("R9 equal held", irq_o, 0);
        idle(2'd2, "R8"); chk("R8 depth2", last_rd, 2);

        // R10: end of interrupt
        wr(2'd2, 0, "R10");
        chk("R10 irq after pop", irq_o, 0);
        idle(2'd3, "R10"); chk("R10 pend", last_rd, 16'h0060);
        wr(2'd2, 0, "R10");
        chk("R10 deferred", irq_o, 1);

        // R4: threshold
        wr(2'd1, 16'h8004, "R4");
        chk("R4 held", irq_o, 0);
        wr(2'd1, 16'h8005, "R4");
        chk("R4 admitted", irq_o, 1);

        // R11: acknowledge and end-of-interrupt together
        step('0, 1, 0, 2'd3, 0, "R11");
        chk("R11 vec5", vec_o, 5);
        step(8'h02, 0, 0, 2'd3, 0, "R11");
        chk("R11 preempt", irq_o, 1);
        step('0, 1, 1, 2'd2, 0, "R11");
        chk("R11 vec1", vec_o, 1);
        idle(2'd2, "R11"); chk("R11 depth", last_rd, 1);
        idle(2'd3, "R11"); chk("R11 pend", last_rd, 16'h0040);
        wr(2'd2, 0, "R10");
        chk("R4 still held", irq_o, 0);

        // R12: end-of-interrupt on empty stack
        wr(2'd2, 0, "R12");
        idle(2'd2, "R12"); chk("R12 depth", last_rd, 0);
        idle(2'd3, "R12"); chk("R12 pend", last_rd, 16'h0040);

        // Random phase against the model
        void'($urandom(32'h5EED_1234));
        held = '0;
        for (int k = 0; k < 3000; k++) begin
            logic ack; logic we; logic [1:0] a; logic [DW-1:0] d; int r;
            for (int i = 0; i < N; i++)
                if ($urandom_range(11) == 0) held[i] = ~held[i];
            ack = ($urandom_range(2) == 0);
            r = $urandom_range(19);
            we = 1'b0; a = 2'($urandom_range(3)); d = '0;
            if (r < 3) begin we = 1'b1; a = 2'd2; end
            else if (r == 3) begin we = 1'b1; a = 2'd0; d = DW'($urandom_range(255)); end
            else if (r == 4) begin
                we = 1'b1; a = 2'd1;
                d = DW'($urandom_range(7));
                d[DW-1] = ($urandom_range(3) != 0);
            end
            step(held, ack, we, a, d, "R9 R8 R11 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule